// File: doc/BRIEF.md
# Multichannel Crossing-Relative Hit Timer

This block timestamps discriminator hits against the beam-crossing period. A fast digitizing clock, phase-locked to the beam clock at an integer ratio `MULT`, runs a single shared fine counter. The counter restarts at every beam-crossing boundary. Each of the `NCH` discriminator inputs has its own synchronizer, edge detector and capture register. The first rising edge a channel sees inside a crossing freezes that channel's copy of the count. Any later edge in the same crossing is dropped.

At each crossing boundary the block copies the finished crossing's hit mask and per-channel times into output registers and raises a one-cycle strobe. The hit mask can also serve directly as the per-crossing trigger primitive bits. An optional dual-edge variant also samples the inputs on the falling clock edge. This adds one half-period bit to every time value.

The control state machine has two states. `ST_WAIT` is entered on reset. The *arm* transition leaves `ST_WAIT` for `ST_ACQ` at the first crossing boundary, and that boundary produces no report. `ST_ACQ` takes the *report* transition, a self-loop, at every later boundary. The *reset* transition returns from either state to `ST_WAIT`.

Top module: `hit_timer`

## Requirements
- R1: A boundary is a rising clock edge at which `beam_clk` samples high after sampling low at the edge before it. At that edge the fine count loads 0. At every other edge it increments by 1.
- R2: In single-edge mode (`DUAL_EDGE`=0) a channel's time is the count value loaded at the edge that captures it. If an input rises between the edge where the count loads j and the next edge, its time is j+3.
- R3: Only the first rising edge of a channel within a crossing is kept. A second rising edge in the same crossing leaves that channel's reported time unchanged.
- R4: At each boundary in `ST_ACQ`, `rd_valid` is high for exactly one cycle. In that cycle `rd_mask` and `rd_times` describe the crossing that just ended. Both hold their values until the next report.
- R5: A channel with no hit in the crossing reports mask bit 0 and time 0.
- R6: If a rising edge is detected at a boundary edge, it belongs to the new crossing with time 0, and it is absent from the report of the crossing that ends there.
- R7: The fine count saturates at `MULT`-1 and never wraps. Any hit captured after saturation reads `MULT`-1.
- R8: After reset the first boundary takes the *arm* transition and gives no report (`rd_valid` stays 0).
- R9: A synchronous `rst` clears `rd_valid`, `rd_mask`, `rd_times`, the count and all captures, and returns the control to `ST_WAIT`.
- R10: In dual-edge mode (`DUAL_EDGE`=1) the time width grows by one bit. An input rising in the first half of the cycle after the count loads j reads 2j+5. One rising in the second half reads 2j+6.
- R11: Bit i of `rd_mask` belongs to channel i. Channel i's time occupies `rd_times[i*TW +: TW]`, where `TW` = clog2(`MULT`) + `DUAL_EDGE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast digitizing clock, `MULT` times the beam clock |
| rst | input | 1 | Synchronous reset, active high |
| beam_clk | input | 1 | Beam clock level, phase-locked to `clk` |
| disc | input | NCH | Asynchronous discriminator outputs |
| rd_valid | output | 1 | One-cycle strobe: a crossing report is present |
| rd_mask | output | NCH | Hit mask of the reported crossing (also trigger bits) |
| rd_times | output | NCH*TW | Per-channel fine times, channel 0 in the low field |

## Verification
The assertions assume that `beam_clk` is phase-locked to `clk` and stays high and low for at least one fast cycle each. This makes consecutive boundaries at least two cycles apart, so the one-cycle strobe check is meaningful. The bench changes `beam_clk` and `disc` one nanosecond after a rising edge, or just after a falling edge for the half-period case. No sampling flop ever sees an input change at its own edge. Each crossing lasts 64 cycles, except one deliberately longer crossing that drives the count into saturation.

// File: rtl/hit_timer_pkg.sv
`timescale 1ns/1ps
package hit_timer_pkg;

    // Control states of the crossing sequencer
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,   // after reset, until the first boundary
        ST_ACQ  = 1'b1    // acquiring; every boundary yields a report
    } ht_state_e;

endpackage

// File: rtl/hit_timer_ctrl.sv
`timescale 1ns/1ps
module hit_timer_ctrl
    import hit_timer_pkg::*;
#(
    parameter int MULT = 64,
    parameter int CW   = $clog2(MULT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beam_clk,
    output logic          bx_start,
    output logic          report,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_next
);

    localparam logic [CW-1:0] CNT_MAX = CW'(MULT - 1);

    ht_state_e state_q, state_d;
    logic      beam_q;

    // beam clock level history for boundary detection
    always_ff @(posedge clk) begin
        if (rst) beam_q <= 1'b0;
        else     beam_q <= beam_clk;
    end

    assign bx_start = beam_clk & ~beam_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    // next state: arm on first boundary, then stay acquiring
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (bx_start) state_d = ST_ACQ;
            ST_ACQ:  state_d = ST_ACQ;
            default: state_d = ST_WAIT;
        endcase
    end

    // outputs: report only boundaries seen while acquiring
    always_comb begin
        report = 1'b0;
        unique case (state_q)
            ST_WAIT: report = 1'b0;
            ST_ACQ:  report = bx_start;
            default: report = 1'b0;
        endcase
    end

    // shared fine counter: restart at boundary, saturate at the top
    always_comb begin
        if (bx_start)             cnt_next = '0;
        else if (cnt == CNT_MAX)  cnt_next = cnt;
        else                      cnt_next = cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_next;
    end

endmodule

// File: rtl/hit_timer_chan.sv
`timescale 1ns/1ps
module hit_timer_chan #(
    parameter int TW   = 6,
    parameter bit DUAL = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          disc_in,
    input  logic          bx_start,
    input  logic [TW-1:0] stamp_rise,
    input  logic [TW-1:0] stamp_fall,
    output logic          hit,
    output logic [TW-1:0] tstamp
);

    logic          sync1, sync2, sync3;
    logic          rise;
    logic          fall_first;
    logic [TW-1:0] stamp;

    // two-flop synchronizer plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= disc_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign rise = sync2 & ~sync3;

    generate
        if (DUAL) begin : g_dual
            logic nsync1, nsync2, nseen;
            // falling-edge synchronizer chain
            always_ff @(negedge clk) begin
                if (rst) begin
                    nsync1 <= 1'b0;
                    nsync2 <= 1'b0;
                end else begin
                    nsync1 <= disc_in;
                    nsync2 <= nsync1;
                end
            end
            // falling chain state when the rising chain's second stage loads
            always_ff @(posedge clk) begin
                if (rst) nseen <= 1'b0;
                else     nseen <= nsync2;
            end
            assign fall_first = nseen;
        end else begin : g_single
            assign fall_first = 1'b0;
        end
    endgenerate

    assign stamp = fall_first ? stamp_fall : stamp_rise;

    // first-edge capture per crossing
    always_ff @(posedge clk) begin
        if (rst) begin
            hit    <= 1'b0;
            tstamp <= '0;
        end else if (bx_start) begin
            hit    <= rise;
            tstamp <= rise ? stamp : '0;
        end else if (rise && !hit) begin
            hit    <= 1'b1;
            tstamp <= stamp;
        end
    end

endmodule

// File: rtl/hit_timer.sv
`timescale 1ns/1ps
module hit_timer #(
    parameter int NCH       = 32,
    parameter int MULT      = 64,
    parameter bit DUAL_EDGE = 1'b0,
    localparam int CW       = $clog2(MULT),
    localparam int TW       = CW + (DUAL_EDGE ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beam_clk,
    input  logic [NCH-1:0]    disc,
    output logic              rd_valid,
    output logic [NCH-1:0]    rd_mask,
    output logic [NCH*TW-1:0] rd_times
);

    logic          bx_start;
    logic          report;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_next;
    logic [TW-1:0] stamp_rise;
    logic [TW-1:0] stamp_fall;

    logic [NCH-1:0]    hits;
    logic [NCH*TW-1:0] tvec;

    hit_timer_ctrl #(.MULT(MULT), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .beam_clk (beam_clk),
        .bx_start (bx_start),
        .report   (report),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    // time stamps offered to the channels
    generate
        if (DUAL_EDGE) begin : g_stamp_dual
            assign stamp_rise = {cnt_next, 1'b0};
            assign stamp_fall = bx_start ? '0 : {cnt, 1'b1};
        end else begin : g_stamp_single
            assign stamp_rise = cnt_next;
            assign stamp_fall = cnt;
        end
    endgenerate

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic [TW-1:0] t_i;
            hit_timer_chan #(.TW(TW), .DUAL(DUAL_EDGE)) u_chan (
                .clk        (clk),
                .rst        (rst),
                .disc_in    (disc[i]),
                .bx_start   (bx_start),
                .stamp_rise (stamp_rise),
                .stamp_fall (stamp_fall),
                .hit        (hits[i]),
                .tstamp     (t_i)
            );
            assign tvec[i*TW +: TW] = hits[i] ? t_i : '0;
        end
    endgenerate

    // report registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_mask  <= '0;
            rd_times <= '0;
        end else if (report) begin
            rd_valid <= 1'b1;
            rd_mask  <= hits;
            rd_times <= tvec;
        end else begin
            rd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/hit_timer_chk.sv
`timescale 1ns/1ps
module hit_timer_chk #(
    parameter int NCH  = 32,
    parameter int MULT = 64,
    parameter int CW   = 6,
    parameter int TW   = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bx_start,
    input logic [CW-1:0]     cnt,
    input logic              rd_valid,
    input logic [NCH-1:0]    rd_mask,
    input logic [NCH*TW-1:0] rd_times
);

    localparam logic [CW-1:0] CNT_MAX = CW'(MULT - 1);

    // R1: count restarts at a boundary
    assert_cnt_restart_R1: assert property (@(posedge clk) disable iff (rst)
        bx_start |=> (cnt == '0));

    // R1: count advances by one between boundaries
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!bx_start && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CW'(1)));

    // R7: count holds at its top value instead of wrapping
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!bx_start && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R4: strobe lasts one cycle
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R4: strobe only follows a boundary
    assert_valid_cause_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bx_start));

    // R4: report contents hold between boundaries
    assert_report_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !bx_start |=> ($stable(rd_mask) && $stable(rd_times)));

    // R9: reset empties the report
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_mask == '0 && rd_times == '0));

    // R5: channels without a hit read zero
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_zero
            assert_nohit_zero_R5: assert property (@(posedge clk) disable iff (rst)
                !rd_mask[i] |-> (rd_times[i*TW +: TW] == '0));
        end
    endgenerate

endmodule

bind hit_timer hit_timer_chk #(
    .NCH  (NCH),
    .MULT (MULT),
    .CW   (CW),
    .TW   (TW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bx_start (bx_start),
    .cnt      (cnt),
    .rd_valid (rd_valid),
    .rd_mask  (rd_mask),
    .rd_times (rd_times)
);

// File: tb/tb_hit_timer.sv
`timescale 1ns/1ps
module tb_hit_timer;

    localparam int NCH  = 32;
    localparam int MULT = 64;
    localparam int TW   = 6;
    localparam int TW2  = 7;

    logic              clk = 1'b0;
    logic              rst;
    logic              beam_clk;
    logic [NCH-1:0]    disc;
    logic              rd_valid;
    logic [NCH-1:0]    rd_mask;
    logic [NCH*TW-1:0] rd_times;
    logic [1:0]        disc2;
    logic              rd_valid2;
    logic [1:0]        rd_mask2;
    logic [2*TW2-1:0]  rd_times2;

    int nchk = 0;
    int nerr = 0;
    int hit1  [NCH];
    int hit2  [NCH];
    int exp_t [NCH];
    int dual_j = -1;

    always #2.5 clk = ~clk;

    hit_timer #(.NCH(NCH), .MULT(MULT), .DUAL_EDGE(1'b0)) dut (
        .clk(clk), .rst(rst), .beam_clk(beam_clk), .disc(disc),
        .rd_valid(rd_valid), .rd_mask(rd_mask), .rd_times(rd_times)
    );

    hit_timer #(.NCH(2), .MULT(MULT), .DUAL_EDGE(1'b1)) dut2 (
        .clk(clk), .rst(rst), .beam_clk(beam_clk), .disc(disc2),
        .rd_valid(rd_valid2), .rd_mask(rd_mask2), .rd_times(rd_times2)
    );

    // {channel, offset j, expected time}
    localparam logic [23:0] VEC [8] = '{
        {8'd0,  8'd0,  8'd3},
        {8'd31, 8'd10, 8'd13},
        {8'd7,  8'd20, 8'd23},
        {8'd16, 8'd40, 8'd43},
        {8'd3,  8'd59, 8'd62},
        {8'd12, 8'd60, 8'd63},
        {8'd20, 8'd5,  8'd8},
        {8'd1,  8'd30, 8'd33}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        for (int c = 0; c < NCH; c++) begin
            hit1[c]  = -1;
            hit2[c]  = -1;
            exp_t[c] = -1;
        end
        dual_j = -1;
    endtask

    // called at boundary edge + 1 ns; ends at the next boundary edge + 1 ns
    task automatic run_crossing(input int len);
        for (int k = 0; k <= len - 2; k++) begin
            for (int c = 0; c < NCH; c++) begin
                if (hit1[c] == k || hit2[c] == k) disc[c] = 1'b1;
                else if (k == 0 || (hit1[c] >= 0 && k == hit1[c] + 4)) disc[c] = 1'b0;
            end
            if (k == 0) disc2 = 2'b00;
            if (k == 1) chk("R4 strobe low after report", rd_valid, 0);
            if (k == len / 2) beam_clk = 1'b0;
            if (k == dual_j) begin
                disc2[0] = 1'b1;
                #2.5;
                disc2[1] = 1'b1;
            end
            step();
        end
        beam_clk = 1'b1;
        step();
    endtask

    task automatic check_out(input string tag);
        logic [NCH-1:0] em;
        em = '0;
        for (int c = 0; c < NCH; c++) if (exp_t[c] >= 0) em[c] = 1'b1;
        chk({tag, " valid"}, rd_valid, 1);
        chk({tag, " mask"}, rd_mask, em);
        for (int c = 0; c < NCH; c++)
            chk({tag, " time"}, rd_times[c*TW +: TW], (exp_t[c] < 0) ? 0 : exp_t[c]);
    endtask

    initial begin
        #(5.0 * 200000);
        nerr++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        rst = 1'b1;
        beam_clk = 1'b0;
        disc = '0;
        disc2 = '0;
        clr();
        repeat (4) step();
        chk("R9 reset valid", rd_valid, 0);
        chk("R9 reset mask", rd_mask, 0);
        chk("R9 reset times", (rd_times == '0), 1);
        rst = 1'b0;
        step();
        beam_clk = 1'b1;
        step();
        chk("R8 no report at arming boundary", rd_valid, 0);

        // table of single-hit crossings (R2, R11)
        for (int v = 0; v < 8; v++) begin
            clr();
            hit1[VEC[v][23:16]]  = int'(VEC[v][15:8]);
            run_crossing(MULT);
            exp_t[VEC[v][23:16]] = int'(VEC[v][7:0]);
            check_out("R2 R11 table");
        end

        // all channels at staggered offsets
        clr();
        for (int c = 0; c < NCH; c++) hit1[c] = c;
        run_crossing(MULT);
        for (int c = 0; c < NCH; c++) exp_t[c] = c + 3;
        check_out("R2 R11 all channels");

        // R3: second edge in the same crossing ignored
        clr();
        hit1[5] = 10;
        hit2[5] = 20;
        run_crossing(MULT);
        exp_t[5] = 13;
        check_out("R3 second edge");

        // R5: empty crossing reads zero everywhere
        clr();
        run_crossing(MULT);
        check_out("R5 empty crossing");

        // R6: edge detected at the boundary goes to the new crossing
        clr();
        hit1[9] = MULT - 3;
        run_crossing(MULT);
        check_out("R6 old crossing");
        clr();
        run_crossing(MULT);
        exp_t[9] = 0;
        check_out("R6 new crossing");

        // R7: long crossing saturates the count
        clr();
        hit1[1] = 90;
        hit1[2] = 59;
        run_crossing(100);
        exp_t[1] = MULT - 1;
        exp_t[2] = 62;
        check_out("R7 saturation");

        // R10: dual-edge half-period bit
        clr();
        dual_j = 10;
        run_crossing(MULT);
        check_out("R10 single dut idle");
        chk("R10 dual valid", rd_valid2, 1);
        chk("R10 dual mask", rd_mask2, 3);
        chk("R10 first-half edge", rd_times2[0 +: TW2], 25);
        chk("R10 second-half edge", rd_times2[TW2 +: TW2], 26);

        // R9: reset in the middle of acquisition
        clr();
        hit1[4] = 5;
        run_crossing(MULT);
        exp_t[4] = 8;
        check_out("R9 before reset");
        rst = 1'b1;
        beam_clk = 1'b0;
        repeat (3) step();
        chk("R9 mid reset valid", rd_valid, 0);
        chk("R9 mid reset mask", rd_mask, 0);
        chk("R9 mid reset times", (rd_times == '0), 1);
        rst = 1'b0;
        step();
        step();
        beam_clk = 1'b1;
        step();
        chk("R8 R9 no report after reset", rd_valid, 0);
        clr();
        hit1[8] = 0;
        run_crossing(MULT);
        exp_t[8] = 3;
        check_out("R9 recovery");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule